// File: doc/BRIEF.md
# Folded Linear-Phase Lowpass FIR

This block is an eight-tap lowpass filter with a symmetric coefficient set, so its phase response is linear. It runs on the sample clock and accepts one unsigned 10-bit sample on every rising edge. A shift register holds the eight most recent samples.

The coefficients mirror each other, so each pair of taps that shares a coefficient is added first. Only four constant multiplications remain. The real-valued coefficients are stored as integers scaled by one thousand: 9, 48, 164 and 279, from the outermost tap pair to the innermost. The four products are summed and the total is divided by 1000, truncating, to return to the input scale. The quotient is clamped to the 10-bit range and registered on the output.

The coefficients sum to exactly 1000, so the DC gain is one. The surrounding design supplies the sample clock and the input stream. The filtered stream is read from the output, one value per sample edge.

Top module: `fold_fir_lp`

## Requirements
- R1: When `rst_n` is low at a rising edge, all eight tap registers and `filt_out` become 0 at that edge.
- R2: On every rising edge outside reset, `smp_in` enters tap 0 and every tap k takes the previous value of tap k-1, so tap k holds the sample captured k edges earlier.
- R3: Tap pairs are pre-added as (0,7), (1,6), (2,5) and (3,4) in 11-bit unsigned arithmetic before multiplication. An asymmetric input ramp must produce outputs that match this pairing.
- R4: The pair sums are weighted by 9, 48, 164 and 279, in the pair order of R3. A lone sample of amplitude A followed by zeros gives the output sequence floor(A·c/1000) for c = 9, 48, 164, 279, 279, 164, 48, 9, then 0.
- R5: The accumulator is wide enough (22 bits) that full-scale input on every tap never overflows. A constant input of 1023 settles to 1023, and the output is clamped to 1023.
- R6: The division by 1000 truncates toward zero. For example, a lone sample of 1 gives all-zero output, and an accumulated 4500 gives 4.
- R7: A sample captured at edge k first affects `filt_out` after edge k+1, which is a latency of one sample period beyond the delay line.
- R8: A constant input C applied after a zeroed history gives `filt_out` equal to C from the eighth output that includes it onward.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sample clock; one sample per rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| smp_in | input | 10 | Unsigned input sample |
| filt_out | output | 10 | Registered filtered sample |

## Verification
The bench drives a lone large pulse and a lone unit pulse. A design with a wrong or swapped coefficient breaks the symmetric pulse response. A design that rounds instead of truncating turns a unit pulse into nonzero output. An ascending ramp catches mis-paired taps, whose sums diverge even when the coefficients are correct. A full-scale constant exposes an accumulator that is too narrow, because its output wraps far below 1023. A mid-stream reset followed by a pulse shows stale taps if reset missed any stage. Every expected value is scheduled two edges after its sample is driven, so an extra or a missing register stage misaligns the whole stream.

// File: rtl/fold_fir_pkg.sv
// Package: shared sizes and the scaled coefficient set of the folded FIR.
// Assumes an even tap count whose pairs map onto the four stored weights.
package fold_fir_pkg;
    localparam int SMP_W   = 10;    // sample width
    localparam int TAPS    = 8;     // filter length
    localparam int COEF_W  = 9;     // holds the largest weight (279)
    localparam int SCALE   = 1000;  // integer scaling of the weights

    // Weight of pre-added pair idx; pair 0 is the outermost (newest+oldest).
    function automatic logic [COEF_W-1:0] pair_coef(input int idx);
        case (idx)
            0:       return COEF_W'(9);
            1:       return COEF_W'(48);
            2:       return COEF_W'(164);
            default: return COEF_W'(279);
        endcase
    endfunction

    // Sum of pair weights; twice this equals the full scaled coefficient sum.
    function automatic int coef_pair_sum(input int npair);
        int s;
        s = 0;
        for (int i = 0; i < npair; i++) s += int'(pair_coef(i));
        return s;
    endfunction
endpackage

// File: rtl/fir_tap_line.sv
// Module: delay line of TAPS sample registers; tap 0 is the newest sample.
// Assumes one new sample per clock edge and a synchronous active-low reset.
module fir_tap_line #(
    parameter int W = 10,
    parameter int N = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [W-1:0]        din,
    output logic [N-1:0][W-1:0] taps
);
    genvar k;
    generate
        for (k = 0; k < N; k++) begin : g_stage
            if (k == 0) begin : g_head
                // Purpose: capture the incoming sample into the first stage.
                always_ff @(posedge clk) begin
                    if (!rst_n) taps[0] <= '0;
                    else        taps[0] <= din;
                end
            end else begin : g_body
                // Purpose: move the sample one stage further down the line.
                always_ff @(posedge clk) begin
                    if (!rst_n) taps[k] <= '0;
                    else        taps[k] <= taps[k-1];
                end
            end
        end
    endgenerate

    AST_TAP_CLEAR: assert property (@(posedge clk) !rst_n |=> (taps[N-1] == '0 && taps[0] == '0)); // R1
    AST_TAP_SHIFT: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> (taps[N-1] == $past(taps[N-2]) && taps[1] == $past(taps[0]))); // R2
endmodule

// File: rtl/fir_pair_mac.sv
// Module: folds mirrored taps, weights each pair sum and accumulates.
// Assumes unsigned samples and an even tap count; purely combinational
// (clk and rst_n only clock the overflow check).
module fir_pair_mac
    import fold_fir_pkg::*;
#(
    parameter int W     = 10,
    parameter int N     = 8,
    parameter int ACC_W = 22
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [N-1:0][W-1:0] taps,
    output logic [ACC_W-1:0]    acc
);
    localparam int NPAIR   = N / 2;
    localparam int PSUM_W  = W + 1;
    localparam int PROD_W  = PSUM_W + COEF_W;
    localparam int ACC_MAX = ((1 << W) - 1) * 2 * coef_pair_sum(NPAIR);

    logic [NPAIR-1:0][PSUM_W-1:0] psum;
    logic [NPAIR-1:0][PROD_W-1:0] prod;

    genvar p;
    generate
        for (p = 0; p < NPAIR; p++) begin : g_pair
            // Pre-add mirrored taps, then weight by the pair coefficient.
            assign psum[p] = {1'b0, taps[p]} + {1'b0, taps[N-1-p]};
            assign prod[p] = PROD_W'(psum[p]) * PROD_W'(pair_coef(p));
        end
    endgenerate

    // Purpose: sum the weighted pairs into the full-width accumulator.
    always_comb begin
        acc = '0;
        for (int i = 0; i < NPAIR; i++) acc += ACC_W'(prod[i]);
    end

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        acc <= ACC_W'(ACC_MAX)); // R5
endmodule

// File: rtl/fir_scale_sat.sv
// Module: divides the accumulator by the coefficient scale (truncating),
// clamps to the output range and registers the result.
// Assumes a non-negative accumulator and a synchronous active-low reset.
module fir_scale_sat #(
    parameter int ACC_W = 22,
    parameter int OUT_W = 10,
    parameter int SCALE = 1000
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [ACC_W-1:0] acc,
    output logic [OUT_W-1:0] out_q
);
    localparam logic [ACC_W-1:0] DIV     = ACC_W'(SCALE);
    localparam logic [ACC_W-1:0] SAT_MAX = ACC_W'((1 << OUT_W) - 1);

    logic [ACC_W-1:0] quot;

    // Purpose: integer division by the constant scale.
    always_comb quot = acc / DIV;

    // Purpose: clamp and register the rescaled result.
    always_ff @(posedge clk) begin
        if (!rst_n)               out_q <= '0;
        else if (quot > SAT_MAX)  out_q <= '1;
        else                      out_q <= quot[OUT_W-1:0];
    end

    AST_OUT_CLEAR: assert property (@(posedge clk) !rst_n |=> out_q == '0); // R1
    AST_TRUNC_FLOOR: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> ((out_q == '1) ||
                          ((ACC_W'(out_q) * DIV <= $past(acc)) &&
                           ($past(acc) - ACC_W'(out_q) * DIV < DIV)))); // R6
endmodule

// File: rtl/fold_fir_lp.sv
// Module: top of the folded linear-phase lowpass FIR.
// Chain: tap line -> pair pre-add/multiply/accumulate -> divide, clamp, register.
// Assumes smp_in changes once per clk edge (clk is the sample clock).
module fold_fir_lp
    import fold_fir_pkg::*;
#(
    parameter int DW = SMP_W,
    parameter int NT = TAPS
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [DW-1:0] smp_in,
    output logic [DW-1:0] filt_out
);
    localparam int NPAIR = NT / 2;
    localparam int ACC_W = DW + 1 + COEF_W + $clog2(NPAIR);

    logic [NT-1:0][DW-1:0] taps;
    logic [ACC_W-1:0]      acc;

    fir_tap_line #(.W(DW), .N(NT)) u_line (
        .clk   (clk),
        .rst_n (rst_n),
        .din   (smp_in),
        .taps  (taps)
    );

    fir_pair_mac #(.W(DW), .N(NT), .ACC_W(ACC_W)) u_mac (
        .clk   (clk),
        .rst_n (rst_n),
        .taps  (taps),
        .acc   (acc)
    );

    fir_scale_sat #(.ACC_W(ACC_W), .OUT_W(DW), .SCALE(SCALE)) u_out (
        .clk   (clk),
        .rst_n (rst_n),
        .acc   (acc),
        .out_q (filt_out)
    );

    AST_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && taps == '0) |=> filt_out == '0); // R7
endmodule

// File: tb/fold_fir_lp_bench.sv
// Scoreboard bench: driver pushes expected outputs two edges ahead,
// monitor pops and compares at each falling edge.
// Latency: sample driven before edge k is captured at k; its first
// contribution appears on filt_out after edge k+1.
module fold_fir_lp_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [9:0] smp_in = '0;
    logic [9:0] filt_out;

    int cyc = 0;
    int n_run = 0;
    int n_fail = 0;
    int hist[8];
    int q_due[$];
    int q_exp[$];
    string q_tag[$];

    always #4 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    fold_fir_lp u_fold_fir_lp (
        .clk      (clk),
        .rst_n    (rst_n),
        .smp_in   (smp_in),
        .filt_out (filt_out)
    );

    function automatic int model_out();
        int s;
        int q;
        s = (hist[0] + hist[7]) * 9 + (hist[1] + hist[6]) * 48
          + (hist[2] + hist[5]) * 164 + (hist[3] + hist[4]) * 279;
        q = s / 1000;
        if (q > 1023) q = 1023;
        return q;
    endfunction

    task automatic check(input string tag, input int act, input int exp);
        n_run++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: filt_out=%0d expected=%0d (cycle %0d)", tag, act, exp, cyc);
        end
    endtask

    // Driver: present one sample and schedule its expected output.
    task automatic push_sample(input int v, input string tag);
        @(negedge clk);
        smp_in = v[9:0];
        for (int i = 7; i > 0; i--) hist[i] = hist[i-1];
        hist[0] = v;
        q_due.push_back(cyc + 2);
        q_exp.push_back(model_out());
        q_tag.push_back(tag);
    endtask

    task automatic apply_reset();
        @(negedge clk);
        rst_n = 1'b0;
        smp_in = 10'd777;
        q_due.delete(); q_exp.delete(); q_tag.delete();
        for (int i = 0; i < 8; i++) hist[i] = 0;
        @(negedge clk);
        check("R1", int'(filt_out), 0);
        rst_n = 1'b1;
        smp_in = '0;
    endtask

    // Monitor: compare every result that falls due in this cycle.
    always @(negedge clk) begin
        while (q_due.size() > 0 && q_due[0] == cyc) begin
            check(q_tag[0], int'(filt_out), q_exp[0]);
            void'(q_due.pop_front());
            void'(q_exp.pop_front());
            q_tag.pop_front();
        end
    end

    initial begin
        #(8 * 200000);
        n_fail++;
        $display("FAIL watchdog: run hung, actual=timeout expected=finish");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        for (int i = 0; i < 8; i++) hist[i] = 0;
        apply_reset();
        // R7: one sample then zeros; first non-zero output two edges later.
        push_sample(1000, "R7");
        for (int i = 0; i < 3; i++) push_sample(0, "R7");
        // R4: large pulse gives the symmetric weight sequence.
        for (int i = 0; i < 6; i++) push_sample(0, "R4");
        push_sample(1023, "R4");
        for (int i = 0; i < 10; i++) push_sample(0, "R4");
        // R6: unit pulse truncates to zero; step of 500 exercises .5 fractions.
        push_sample(1, "R6");
        for (int i = 0; i < 9; i++) push_sample(0, "R6");
        // R8: constant settles to itself.
        for (int i = 0; i < 12; i++) push_sample(500, "R8");
        // R5: full-scale constant without overflow.
        for (int i = 0; i < 12; i++) push_sample(1023, "R5");
        // R3: asymmetric ramp reveals tap pairing.
        for (int i = 0; i < 16; i++) push_sample(i * 61, "R3");
        // R2: alternating pattern through the delay line.
        for (int i = 0; i < 16; i++) push_sample((i % 2 == 0) ? 900 : 37, "R2");
        // R1: mid-stream reset, then a pulse must see a cleared history.
        for (int i = 0; i < 5; i++) push_sample(800, "R1");
        apply_reset();
        push_sample(300, "R1");
        for (int i = 0; i < 10; i++) push_sample(0, "R1");
        repeat (3) @(negedge clk);
        if (q_due.size() != 0) begin
            n_run++;
            n_fail++;
            $display("FAIL scoreboard: pending=%0d expected=0", q_due.size());
        end
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule